// File: doc/BRIEF.md
# Instruction Cycle and Fetch Sequencer

This block paces a small processor core. It divides the oscillator clock into instruction cycles of four phases each and holds the program counter. It overlaps execution with fetch: the word read from program memory during one instruction cycle is the word executed in the next. It does not decode instructions. A separate decoder examines the word being executed and reports three things: whether that word opens a two-word instruction, whether it redirects the program counter (and to which address), and whether a conditional test came out true, which means the next instruction is skipped.

From these reports the sequencer decides how many instruction cycles each instruction occupies. A redirect or a taken skip discards the word fetched in the same cycle, and a NOP cycle takes its place. A second instruction word carries all ones in its top four bits. When such a word is reached without the first word just before it, it executes as a NOP. As a result, skipping over a two-word instruction costs two NOP cycles, and a two-word branch takes three cycles.

Top module: `insn_cycle_seq`

## Requirements
- R1: `phase` counts 0,1,2,3 (Q1..Q4) and advances by one on every clock edge out of reset. Phase 3 (Q4) is the last clock of an instruction cycle.
- R2: Synchronous reset, active high, sets `phase` to 0 and `pm_addr` to 0. The first cycle after reset executes a NOP with `nop_insert` high. The next cycle executes the word at address 0.
- R3: `pm_addr` is constant within an instruction cycle. With no redirect, it rises by one (modulo 2^ADDR_W) at each cycle boundary. The word on `pm_data` at the end of a cycle is the word executed in the following cycle.
- R4: Single-word instructions with no redirect and no skip execute back to back, one instruction cycle each.
- R5: `pc_change` high during Q4 makes the next cycle a NOP with `nop_insert` high and `pm_addr` equal to `pc_target`. The target word executes in the cycle after that, so the instruction occupies two cycles. This includes a target of the highest address, after which `pm_addr` wraps to 0.
- R6: `cond_true` high during Q4 discards the word fetched in that cycle. The next cycle is a NOP with `nop_insert` high, and `pm_addr` keeps rising by one.
- R7: `two_word` high during Q4 marks the executing word as a first word. The next word (top four bits 1111) then executes normally, with `nop_insert` low.
- R8: A word whose top four bits are 1111, executed without `two_word` having been reported in the previous cycle, appears as `exec_word` = 0x0000 with `nop_insert` high.
- R9: A two-word branch reports `two_word` on its first word and `pc_change` on its second word. It occupies three instruction cycles: first word, second word, NOP.
- R10: A taken skip over a two-word instruction yields two NOP cycles, one for the discarded first word and one for the lone second word.
- R11: When `pc_change` and `cond_true` are both high, the redirect wins and `pm_addr` takes `pc_target`.
- R12: `exec_word` is 0x0000 whenever `nop_insert` is high. `exec_word` and `nop_insert` change only at cycle boundaries.
- R13: `two_word`, `pc_change` and `cond_true` are ignored during a cycle that executes a NOP. `pm_addr` then keeps rising by one, and the following word executes normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| pm_data | input | WORD_W | Program word read at `pm_addr` |
| two_word | input | 1 | Executing word opens a two-word instruction |
| pc_change | input | 1 | Executing instruction redirects the program counter |
| cond_true | input | 1 | Conditional test taken; skip the next instruction |
| pc_target | input | ADDR_W | Redirect address, used with `pc_change` |
| phase | output | 2 | Phase in the instruction cycle, 0..3 = Q1..Q4 |
| exec_word | output | WORD_W | Word executed in the current cycle (0x0000 for a NOP) |
| nop_insert | output | 1 | Current cycle executes an inserted NOP |
| pm_addr | output | ADDR_W | Program memory fetch address |

## Verification
The sequencer is driven through a straight run of single-word instructions, which should give one cycle per word and a steadily rising address. The same run is also broken by jumps, taken skips and two-word instructions, so that the number of inserted NOP cycles separates a one-word redirect (one NOP), a skip over a two-word instruction (two NOPs) and a two-word branch (three cycles in all). Further cases set skip and jump together, assert decoder reports during a NOP cycle, and place a lone second word in plain flow. These show whether the jump takes priority, whether reports during a NOP are discarded, and whether the marker check depends on the pairing with a preceding first word. A jump to the top address and a reset in the middle of a cycle cover address wrap-around and restart.

// File: rtl/iseq_pkg.sv
package iseq_pkg;

    typedef enum logic [1:0] {
        Q1 = 2'd0,
        Q2 = 2'd1,
        Q3 = 2'd2,
        Q4 = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_SKIP = 2'd1,
        RD_JUMP = 2'd2
    } redir_e;

endpackage

// File: rtl/iseq_phase.sv
module iseq_phase
    import iseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_e phase,
    output logic   cycle_end
);

    typedef struct packed {
        phase_e ph;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.ph = phase_e'(st_q.ph + 2'd1);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{ph: Q1};
        else     st_q <= st_d;
    end

    assign phase     = st_q.ph;
    assign cycle_end = (st_q.ph == Q4);

    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
        cycle_end |=> phase == Q1); // R1

endmodule

// File: rtl/iseq_pc.sv
module iseq_pc
    import iseq_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cycle_end,
    input  redir_e            kind,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] pc
);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cycle_end) begin
            if (kind == RD_JUMP) st_d.pc = target;
            else                 st_d.pc = st_q.pc + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{pc: '0};
        else     st_q <= st_d;
    end

    assign pc = st_q.pc;

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cycle_end |=> $stable(pc)); // R3

endmodule

// File: rtl/iseq_fetch.sv
module iseq_fetch
    import iseq_pkg::*;
#(
    parameter int              WORD_W   = 16,
    parameter int              MARK_W   = 4,
    parameter logic [WORD_W-1:0] NOP_WORD = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cycle_end,
    input  redir_e            kind,
    input  logic              two_word_in,
    input  logic [WORD_W-1:0] fetch_data,
    output logic [WORD_W-1:0] exec_word,
    output logic              nop_insert
);

    localparam int MARK_LO = WORD_W - MARK_W;

    typedef struct packed {
        logic [WORD_W-1:0] ir;
        logic              flushed;
        logic              paired;
    } st_t;

    st_t  st_d, st_q;
    logic lone;

    assign lone       = (&st_q.ir[WORD_W-1:MARK_LO]) && !st_q.paired;
    assign nop_insert = st_q.flushed || lone;
    assign exec_word  = nop_insert ? NOP_WORD : st_q.ir;

    always_comb begin
        st_d = st_q;
        if (cycle_end) begin
            if (kind != RD_NONE) begin
                st_d.ir      = NOP_WORD;
                st_d.flushed = 1'b1;
                st_d.paired  = 1'b0;
            end else begin
                st_d.ir      = fetch_data;
                st_d.flushed = 1'b0;
                st_d.paired  = two_word_in && !nop_insert;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{ir: NOP_WORD, flushed: 1'b1, paired: 1'b0};
        else     st_q <= st_d;
    end

    AST_FLUSH_NOP: assert property (@(posedge clk) disable iff (rst)
        cycle_end && (kind != RD_NONE) |=> nop_insert); // R6

    AST_PAIR_RUNS: assert property (@(posedge clk) disable iff (rst)
        cycle_end && two_word_in && !nop_insert && (kind == RD_NONE) |=> !nop_insert); // R7

endmodule

// File: rtl/insn_cycle_seq.sv
module insn_cycle_seq
    import iseq_pkg::*;
#(
    parameter int                ADDR_W   = 10,
    parameter int                WORD_W   = 16,
    parameter int                MARK_W   = 4,
    parameter logic [WORD_W-1:0] NOP_WORD = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] pm_data,
    input  logic              two_word,
    input  logic              pc_change,
    input  logic              cond_true,
    input  logic [ADDR_W-1:0] pc_target,
    output logic [1:0]        phase,
    output logic [WORD_W-1:0] exec_word,
    output logic              nop_insert,
    output logic [ADDR_W-1:0] pm_addr
);

    phase_e ph;
    logic   cycle_end;
    redir_e kind;

    // Decoder reports count only while a real instruction executes; jump beats skip.
    always_comb begin
        kind = RD_NONE;
        if (!nop_insert) begin
            if (pc_change)      kind = RD_JUMP;
            else if (cond_true) kind = RD_SKIP;
        end
    end

    iseq_phase u_phase (
        .clk       (clk),
        .rst       (rst),
        .phase     (ph),
        .cycle_end (cycle_end)
    );

    iseq_pc #(.ADDR_W(ADDR_W)) u_pc (
        .clk       (clk),
        .rst       (rst),
        .cycle_end (cycle_end),
        .kind      (kind),
        .target    (pc_target),
        .pc        (pm_addr)
    );

    iseq_fetch #(
        .WORD_W   (WORD_W),
        .MARK_W   (MARK_W),
        .NOP_WORD (NOP_WORD)
    ) u_fetch (
        .clk         (clk),
        .rst         (rst),
        .cycle_end   (cycle_end),
        .kind        (kind),
        .two_word_in (two_word && !pc_change && !cond_true),
        .fetch_data  (pm_data),
        .exec_word   (exec_word),
        .nop_insert  (nop_insert)
    );

    assign phase = ph;

    AST_JUMP_ADDR: assert property (@(posedge clk) disable iff (rst)
        cycle_end && pc_change && !nop_insert |=> pm_addr == $past(pc_target)); // R5

    AST_SKIP_ADDR: assert property (@(posedge clk) disable iff (rst)
        cycle_end && cond_true && !pc_change && !nop_insert
        |=> pm_addr == ADDR_W'($past(pm_addr) + 1'b1)); // R6

    AST_NOP_IGNORES: assert property (@(posedge clk) disable iff (rst)
        cycle_end && nop_insert |=> pm_addr == ADDR_W'($past(pm_addr) + 1'b1)); // R13

    AST_EXEC_STABLE: assert property (@(posedge clk) disable iff (rst)
        !cycle_end |=> $stable(exec_word) && $stable(nop_insert)); // R12

endmodule

// File: tb/insn_cycle_seq_test.sv
module insn_cycle_seq_test;

    localparam int ADDR_W = 10;
    localparam int WORD_W = 16;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int NV     = 23;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [WORD_W-1:0] pm_data;
    logic              two_word = 1'b0;
    logic              pc_change = 1'b0;
    logic              cond_true = 1'b0;
    logic [ADDR_W-1:0] pc_target = '0;
    logic [1:0]        phase;
    logic [WORD_W-1:0] exec_word;
    logic              nop_insert;
    logic [ADDR_W-1:0] pm_addr;

    logic [WORD_W-1:0] mem [0:DEPTH-1];

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    assign pm_data = mem[pm_addr];

    insn_cycle_seq #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) uut (
        .clk        (clk),
        .rst        (rst),
        .pm_data    (pm_data),
        .two_word   (two_word),
        .pc_change  (pc_change),
        .cond_true  (cond_true),
        .pc_target  (pc_target),
        .phase      (phase),
        .exec_word  (exec_word),
        .nop_insert (nop_insert),
        .pm_addr    (pm_addr)
    );

    // Fields: req[43:40] tw[39] jmp[38] cnd[37] tgt[36:27] word[26:11] nop[10] addr[9:0]
    localparam logic [43:0] VEC [0:NV-1] = '{
        {4'd2,  1'b0, 1'b0, 1'b0, 10'h000, 16'h0000, 1'b1, 10'h000}, // R2 reset NOP
        {4'd2,  1'b0, 1'b0, 1'b0, 10'h000, 16'h1000, 1'b0, 10'h001}, // R2 word 0
        {4'd4,  1'b1, 1'b0, 1'b0, 10'h000, 16'h1001, 1'b0, 10'h002}, // R4 first word
        {4'd7,  1'b0, 1'b0, 1'b0, 10'h000, 16'hF002, 1'b0, 10'h003}, // R7 paired second
        {4'd4,  1'b0, 1'b1, 1'b0, 10'h020, 16'h1003, 1'b0, 10'h004}, // R4 jump
        {4'd5,  1'b1, 1'b1, 1'b1, 10'h100, 16'h0000, 1'b1, 10'h020}, // R5 R13 NOP
        {4'd13, 1'b0, 1'b0, 1'b1, 10'h000, 16'h1020, 1'b0, 10'h021}, // R13 skip
        {4'd6,  1'b0, 1'b0, 1'b0, 10'h000, 16'h0000, 1'b1, 10'h022}, // R6 skipped
        {4'd6,  1'b0, 1'b0, 1'b1, 10'h000, 16'h1022, 1'b0, 10'h023}, // R6 skip 2w
        {4'd10, 1'b0, 1'b0, 1'b0, 10'h000, 16'h0000, 1'b1, 10'h024}, // R10 NOP one
        {4'd10, 1'b0, 1'b0, 1'b0, 10'h000, 16'h0000, 1'b1, 10'h025}, // R10 NOP two
        {4'd4,  1'b1, 1'b0, 1'b0, 10'h000, 16'h1025, 1'b0, 10'h026}, // R4 branch w1
        {4'd9,  1'b0, 1'b1, 1'b0, 10'h040, 16'hF026, 1'b0, 10'h027}, // R9 branch w2
        {4'd9,  1'b0, 1'b0, 1'b0, 10'h000, 16'h0000, 1'b1, 10'h040}, // R9 third cycle
        {4'd11, 1'b0, 1'b1, 1'b1, 10'h050, 16'h1040, 1'b0, 10'h041}, // R11 both
        {4'd11, 1'b0, 1'b0, 1'b0, 10'h000, 16'h0000, 1'b1, 10'h050}, // R11 jump won
        {4'd3,  1'b0, 1'b0, 1'b0, 10'h000, 16'h1050, 1'b0, 10'h051}, // R3
        {4'd3,  1'b0, 1'b0, 1'b0, 10'h000, 16'h1051, 1'b0, 10'h052}, // R3
        {4'd8,  1'b0, 1'b0, 1'b0, 10'h000, 16'h0000, 1'b1, 10'h053}, // R8 lone
        {4'd3,  1'b0, 1'b1, 1'b0, 10'h3FF, 16'h1053, 1'b0, 10'h054}, // R3 jump top
        {4'd5,  1'b0, 1'b0, 1'b0, 10'h000, 16'h0000, 1'b1, 10'h3FF}, // R5 top
        {4'd3,  1'b0, 1'b0, 1'b0, 10'h000, 16'h13FF, 1'b0, 10'h000}, // R3 wrap
        {4'd3,  1'b0, 1'b0, 1'b0, 10'h000, 16'h1000, 1'b0, 10'h001}  // R3 after wrap
    };

    task automatic chk(input bit ok, input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Entered at the negedge inside Q1 of a cycle; leaves at Q1 of the next.
    task automatic run_vec(input int i);
        logic [43:0]       v;
        int                rq;
        logic [WORD_W-1:0] w0;
        logic              n0;
        v  = VEC[i];
        rq = int'(v[43:40]);
        chk(phase == 2'd0, 1, "phase Q1", 32'(phase), 32'd0);
        chk(exec_word == v[26:11], rq, "exec_word", 32'(exec_word), 32'(v[26:11]));
        chk(nop_insert == v[10], rq, "nop_insert", 32'(nop_insert), 32'(v[10]));
        chk(pm_addr == v[9:0], rq, "pm_addr", 32'(pm_addr), 32'(v[9:0]));
        two_word  = v[39];
        pc_change = v[38];
        cond_true = v[37];
        pc_target = v[36:27];
        w0 = exec_word;
        n0 = nop_insert;
        for (int k = 1; k < 4; k++) begin
            @(negedge clk);
            chk(phase == 2'(k), 1, "phase step", 32'(phase), 32'(k));
            chk(exec_word == w0 && nop_insert == n0, 12, "stable in cycle",
                {15'd0, nop_insert, exec_word}, {15'd0, n0, w0});
        end
        @(negedge clk);
        two_word  = 1'b0;
        pc_change = 1'b0;
        cond_true = 1'b0;
    endtask

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int a = 0; a < DEPTH; a++) mem[a] = 16'h1000 | 16'(a);
        mem[10'h002] = 16'hF002;
        mem[10'h024] = 16'hF024;
        mem[10'h026] = 16'hF026;
        mem[10'h052] = 16'hF052;

        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R2: reset state
        chk(phase == 2'd0, 2, "reset phase", 32'(phase), 32'd0);
        chk(pm_addr == '0, 2, "reset pm_addr", 32'(pm_addr), 32'd0);
        chk(nop_insert == 1'b1, 2, "reset nop", 32'(nop_insert), 32'd1);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) run_vec(i);

        // R2: reset in the middle of a cycle restarts at Q1, address 0, NOP
        @(negedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(phase == 2'd0, 2, "mid reset phase", 32'(phase), 32'd0);
        chk(pm_addr == '0, 2, "mid reset pm_addr", 32'(pm_addr), 32'd0);
        chk(nop_insert == 1'b1, 2, "mid reset nop", 32'(nop_insert), 32'd1);
        chk(exec_word == '0, 12, "mid reset word", 32'(exec_word), 32'd0);
        rst = 1'b0;
        run_vec(0);
        run_vec(1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule